// File: doc/BRIEF.md
# Segmented Base-Bounds Address Translator

This unit turns a 14-bit virtual address into a physical address through a small table of per-segment relocation registers. The two most significant address bits pick one of three segments (code, heap, stack); the remaining 12 bits are an offset into that segment. The offset is compared against the segment's limit. If it fits, the segment's base is added to form the physical address. If it does not fit, or the selector names the unused fourth segment, the unit reports a fault.

Instruction fetches and data loads or stores use the same path. A request is captured on a clock edge together with a snapshot of the selected segment's base and limit. The response appears on the next cycle. A separate write port reloads any segment's base and limit. Because of the snapshot, a write in the same cycle as a request only affects requests that come after it.

Top module: `segbb_xlate`

## Requirements
- R1: After reset the segment table holds code base 0x4000 limit 0xFFF, heap base 0x5800 limit 0xFFF, stack base 0x6800 limit 0x7FF, and no response is valid. Virtual 0x0010 maps to 0x4010, virtual 0x1100 maps to 0x5900, and virtual 0x2000 maps to 0x6800.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high at a rising edge, and low otherwise. Back-to-back requests give back-to-back responses in order.
- R3: The selector is `req_vaddr[13:12]` and the offset is `req_vaddr[11:0]`. When the offset is not above the limit, `rsp_paddr` equals base plus offset (modulo 2^16) and `rsp_fault` is 0.
- R4: When the offset is greater than the selected segment's limit, `rsp_fault` is 1 and `rsp_paddr` is 0.
- R5: Selector value 3 always gives `rsp_fault` = 1 and `rsp_paddr` = 0.
- R6: A write with `cfg_we` = 1 loads `cfg_base` and `cfg_bound` into segment `cfg_seg` (0 to 2). Requests accepted afterwards use the new values.
- R7: A request accepted in the same cycle as a write to its own segment is translated with the values from before the write. The next request sees the new values.
- R8: A write with `cfg_seg` = 3 changes nothing. Segments 0 to 2 keep their values, and selector 3 still faults.
- R9: While `rsp_valid` is 0, `rsp_paddr` and `rsp_fault` are both 0.
- R10: An offset exactly equal to the limit is accepted and translated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present this cycle |
| req_vaddr | input | 14 | Virtual address: selector in bits 13:12, offset in bits 11:0 |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_seg | input | 2 | Segment to write |
| cfg_base | input | 16 | New base address |
| cfg_bound | input | 12 | New limit (largest legal offset) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 16 | Physical address; 0 on fault or idle |
| rsp_fault | output | 1 | Limit violation or unused selector |

## Verification
A register write and a translation can fall in the same cycle. They collide when the request reads the segment that the write is reloading. The bench drives `req_valid` and `cfg_we` in one cycle on the heap segment. It expects the captured request to carry the old base and limit, and the next request to carry the new ones. Its reference table is updated only after the expected result of the colliding request has been computed. A write to the unused selector is also issued together with requests to every segment, to show that it leaves the table unchanged.

// File: rtl/segbb_pkg.sv
package segbb_pkg;

    localparam int VA_W_DEF  = 14;
    localparam int SEL_W_DEF = 2;
    localparam int PA_W_DEF  = 16;
    localparam int NSEG_DEF  = 3;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_HEAP  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_NONE  = 2'd3
    } seg_e;

    // Power-up base of each segment
    function automatic logic [31:0] rst_base(input int idx);
        case (idx)
            int'(SEG_CODE):  rst_base = 32'h0000_4000;
            int'(SEG_HEAP):  rst_base = 32'h0000_5800;
            int'(SEG_STACK): rst_base = 32'h0000_6800;
            default:         rst_base = 32'h0;
        endcase
    endfunction

    // Power-up limit (largest legal offset) of each segment
    function automatic logic [31:0] rst_bound(input int idx);
        case (idx)
            int'(SEG_CODE):  rst_bound = 32'h0000_0FFF;
            int'(SEG_HEAP):  rst_bound = 32'h0000_0FFF;
            int'(SEG_STACK): rst_bound = 32'h0000_07FF;
            default:         rst_bound = 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/segbb_table.sv
module segbb_table #(
    parameter int NSEG  = segbb_pkg::NSEG_DEF,
    parameter int SEL_W = segbb_pkg::SEL_W_DEF,
    parameter int PA_W  = segbb_pkg::PA_W_DEF,
    parameter int OFF_W = segbb_pkg::VA_W_DEF - segbb_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_bound,
    input  logic [SEL_W-1:0] rd_sel,
    output logic             rd_hit,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W-1:0] rd_bound
);

    logic [PA_W-1:0]  base_arr  [NSEG];
    logic [OFF_W-1:0] bound_arr [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        logic [PA_W-1:0]  base_d,  base_q;
        logic [OFF_W-1:0] bound_d, bound_q;

        always_comb begin
            base_d  = base_q;
            bound_d = bound_q;
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                base_d  = wr_base;
                bound_d = wr_bound;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q  <= PA_W'(segbb_pkg::rst_base(g));
                bound_q <= OFF_W'(segbb_pkg::rst_bound(g));
            end else begin
                base_q  <= base_d;
                bound_q <= bound_d;
            end
        end

        assign base_arr[g]  = base_q;
        assign bound_arr[g] = bound_q;
    end

    always_comb begin
        rd_hit   = 1'b0;
        rd_base  = '0;
        rd_bound = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_hit   = 1'b1;
                rd_base  = base_arr[i];
                rd_bound = bound_arr[i];
            end
        end
    end

endmodule

// File: rtl/segbb_core.sv
module segbb_core #(
    parameter int PA_W  = segbb_pkg::PA_W_DEF,
    parameter int OFF_W = segbb_pkg::VA_W_DEF - segbb_pkg::SEL_W_DEF
) (
    input  logic             vld,
    input  logic             hit,
    input  logic [OFF_W-1:0] off,
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] bound,
    output logic [PA_W-1:0]  paddr,
    output logic             fault
);

    logic in_range;

    always_comb begin
        in_range = hit && (off <= bound);
        fault    = vld && !in_range;
        paddr    = (vld && in_range) ? (base + PA_W'(off)) : '0;
    end

endmodule

// File: rtl/segbb_xlate.sv
module segbb_xlate #(
    parameter int VA_W  = segbb_pkg::VA_W_DEF,
    parameter int SEL_W = segbb_pkg::SEL_W_DEF,
    parameter int PA_W  = segbb_pkg::PA_W_DEF,
    parameter int NSEG  = segbb_pkg::NSEG_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_seg,
    input  logic [PA_W-1:0]         cfg_base,
    input  logic [VA_W-SEL_W-1:0]   cfg_bound,
    output logic                    rsp_valid,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic                    rsp_fault
);

    localparam int OFF_W = VA_W - SEL_W;

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [OFF_W-1:0] off;
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] bound;
    } cap_t;

    cap_t st_d, st_q;

    logic [SEL_W-1:0] sel;
    logic             lk_hit;
    logic [PA_W-1:0]  lk_base;
    logic [OFF_W-1:0] lk_bound;

    assign sel = req_vaddr[VA_W-1:OFF_W];

    segbb_table #(
        .NSEG (NSEG),
        .SEL_W(SEL_W),
        .PA_W (PA_W),
        .OFF_W(OFF_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_seg),
        .wr_base (cfg_base),
        .wr_bound(cfg_bound),
        .rd_sel  (sel),
        .rd_hit  (lk_hit),
        .rd_base (lk_base),
        .rd_bound(lk_bound)
    );

    // Snapshot of the segment entry taken when the request is accepted
    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.vld   = 1'b1;
            st_d.hit   = lk_hit;
            st_d.off   = req_vaddr[OFF_W-1:0];
            st_d.base  = lk_base;
            st_d.bound = lk_bound;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    segbb_core #(
        .PA_W (PA_W),
        .OFF_W(OFF_W)
    ) u_core (
        .vld  (st_q.vld),
        .hit  (st_q.hit),
        .off  (st_q.off),
        .base (st_q.base),
        .bound(st_q.bound),
        .paddr(rsp_paddr),
        .fault(rsp_fault)
    );

    assign rsp_valid = st_q.vld;

endmodule

// File: rtl/segbb_xlate_chk.sv
module segbb_xlate_chk #(
    parameter int SEL_W = 2,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEL_W-1:0] req_sel,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault
);

    // R2
    req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && !rsp_fault));

    // R5
    unused_sel_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel == '1) |=> rsp_fault);

    // R4
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

endmodule

bind segbb_xlate segbb_xlate_chk #(
    .SEL_W(SEL_W),
    .PA_W (PA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_sel  (req_vaddr[VA_W-1 -: SEL_W]),
    .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
);

// File: tb/segbb_xlate_bench.sv
module segbb_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_seg = '0;
    logic [15:0] cfg_base = '0;
    logic [11:0] cfg_bound = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    logic [15:0] m_base  [4];
    logic [11:0] m_bound [4];
    logic [16:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    segbb_xlate u_segbb_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic [16:0] model(input logic [13:0] va);
        logic [1:0]  s = va[13:12];
        logic [11:0] o = va[11:0];
        if (s == 2'd3 || o > m_bound[s]) return {1'b1, 16'h0};
        return {1'b0, 16'(m_base[s] + {4'h0, o})};
    endfunction

    task automatic step(input logic rv, input logic [13:0] va, input logic we,
                        input logic [1:0] ws, input logic [15:0] wb,
                        input logic [11:0] wbd, input string tag);
        @(negedge clk);
        req_valid = rv; req_vaddr = va;
        cfg_we = we; cfg_seg = ws; cfg_base = wb; cfg_bound = wbd;
        if (rv) begin
            exp_q.push_back(model(va));
            tag_q.push_back(tag);
        end
        if (we && ws != 2'd3) begin
            m_base[ws]  = wb;
            m_bound[ws] = wbd;
        end
    endtask

    task automatic xl(input logic [13:0] va, input string tag);
        step(1'b1, va, 1'b0, 2'd0, 16'h0, 12'h0, tag);
    endtask

    task automatic idle();
        step(1'b0, 14'h0, 1'b0, 2'd0, 16'h0, 12'h0, "");
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (rsp_valid) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        failures++;
                        $display("FAIL R2 unexpected response: paddr=%h fault=%b expected none",
                                 rsp_paddr, rsp_fault);
                    end else begin
                        logic [16:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if ({rsp_fault, rsp_paddr} !== e) begin
                            failures++;
                            $display("FAIL %s: fault=%b paddr=%h expected fault=%b paddr=%h",
                                     t, rsp_fault, rsp_paddr, e[16], e[15:0]);
                        end
                    end
                end else begin
                    checks++;
                    if (exp_q.size() != 0) begin
                        failures++;
                        $display("FAIL R2 missing response: rsp_valid=0 expected 1");
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                    end else if (rsp_paddr !== 16'h0 || rsp_fault !== 1'b0) begin
                        failures++;
                        $display("FAIL R9 idle outputs: paddr=%h fault=%b expected 0000 0",
                                 rsp_paddr, rsp_fault);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_base[0] = 16'h4000; m_bound[0] = 12'hFFF;
        m_base[1] = 16'h5800; m_bound[1] = 12'hFFF;
        m_base[2] = 16'h6800; m_bound[2] = 12'h7FF;
        m_base[3] = 16'h0000; m_bound[3] = 12'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;   // R1 reset state
        if (rsp_valid !== 1'b0 || rsp_paddr !== 16'h0 || rsp_fault !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: valid=%b paddr=%h fault=%b expected 0 0000 0",
                     rsp_valid, rsp_paddr, rsp_fault);
        end
        mon_en = 1'b1;

        // R1 power-up table
        xl(14'h0010, "R1 code 0x0010");
        xl(14'h1100, "R1 heap 0x1100");
        xl(14'h2000, "R1 stack 0x2000");
        idle();
        // R3 back-to-back translations
        xl(14'h0ABC, "R3 code 0x0ABC");
        xl(14'h1234, "R3 heap 0x1234");
        idle(); idle();
        // R10 offset equal to limit
        xl(14'h0FFF, "R10 code at limit");
        xl(14'h27FF, "R10 stack at limit");
        // R4 beyond limit
        xl(14'h2800, "R4 stack limit+1");
        xl(14'h2FFF, "R4 stack far");
        // R5 unused selector
        xl(14'h3000, "R5 selector 3 low");
        xl(14'h3ABC, "R5 selector 3 high");
        idle();
        // R6 reload stack segment
        step(1'b0, 14'h0, 1'b1, 2'd2, 16'h9000, 12'h0FF, "");
        xl(14'h2050, "R6 stack new base");
        xl(14'h2100, "R6 stack new limit");
        idle();
        // R7 write and request to heap in the same cycle
        step(1'b1, 14'h1010, 1'b1, 2'd1, 16'hA000, 12'h010, "R7 same-cycle uses old");
        xl(14'h1010, "R7 next uses new base");
        xl(14'h1011, "R7 next uses new limit");
        idle();
        // R8 write to selector 3 ignored
        step(1'b0, 14'h0, 1'b1, 2'd3, 16'h1234, 12'hFFF, "");
        xl(14'h3000, "R8 selector 3 still faults");
        xl(14'h0010, "R8 code unchanged");
        xl(14'h1010, "R8 heap unchanged");
        xl(14'h2050, "R8 stack unchanged");
        // R3 wrap of base plus offset
        step(1'b0, 14'h0, 1'b1, 2'd0, 16'hFF00, 12'hFFF, "");
        xl(14'h0200, "R3 wrap modulo 2^16");
        idle(); idle(); idle();

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 leftover responses: %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule